// File: doc/BRIEF.md
# Bipolar converter serial frame master

This block is the host side of a serial link to a four-channel converter that returns a 12-bit magnitude with a sign bit. One request from the user runs one conversion frame. The block pulls chip select low and waits a setup delay that depends on the selected input range. It then produces sixteen serial clock periods from the system clock through a programmable half-period divider. During the frame it shifts a 16-bit command word out on the data-in line, most significant bit first, and collects the returned bits from the data-out line.

At the end of the frame the block splits the returned word into a 2-bit channel tag, a sign flag and a 13-bit two's-complement sample. It pulses a one-cycle valid strobe and then keeps chip select high for a guaranteed quiet interval. A request that arrives while a frame or the quiet interval is in progress is kept in a single pending slot, together with its own command, range and divider setting. That frame starts as soon as the interval has elapsed.

All timing limits are given as nanoseconds and frequencies and turned into system-clock cycle counts at elaboration. The counts quoted below are those for the default parameters with a 100 MHz system clock.

Top module: `afm_frame_master`

## Requirements
- R1: While reset is asserted, chip select and the serial clock are high, data-in is low, and busy and the result strobe are low.
- R2: Each frame produces exactly 16 serial-clock falling edges while chip select is low. The serial clock stays high whenever chip select is high.
- R3: Within a frame the serial clock's low phase and high phase each last exactly the effective half-period, in system-clock cycles, so the duty cycle is 50 %.
- R4: The requested half-period is clamped into the legal range of 5 to 1000 cycles, which is 10 MHz to 50 kHz. A request of 0 or 1 runs at 5 and a request of 1100 runs at 1000. The value is taken when the frame starts.
- R5: The delay from chip select falling to the first serial-clock falling edge is 3 cycles when the bipolar range is selected (range input 0) and 5 cycles when the unipolar range is selected (range input 1).
- R6: Data-in carries command bit 15 from the cycle in which chip select falls, then bits 14 down to 0. It changes only on serial-clock rising edges, so every bit is stable across the falling edge at which it is taken.
- R7: Data-out is sampled at the first 15 falling edges, so the returned word is read bit 15 first and its bit 0 is a filler bit. The result channel is word bits 15:14, the sign is word bit 13, and the value is word bits 13:1 as a 13-bit two's-complement number.
- R8: The result strobe is high for exactly one cycle, the cycle in which chip select returns high. The result fields hold their value until the next strobe.
- R9: Between frames chip select stays high for at least 9 cycles, which is an 8-cycle quiet interval plus one launch cycle.
- R10: Busy is high from the chip-select fall to the end of the quiet interval. A start seen while busy is held, with the command, range and divider present at that moment, and that frame begins on the cycle after the interval. A further start while one is held is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle frame request |
| cmd_word | input | 16 | Command word shifted out on data-in |
| range_unipolar | input | 1 | 1 selects the longer unipolar setup delay |
| half_div | input | DIV_W (12) | Requested serial-clock half-period in system cycles |
| busy | output | 1 | Frame or quiet interval in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 2 | Channel tag of the last result |
| res_sign | output | 1 | Sign bit of the last result |
| res_value | output | 13 | Two's-complement sample of the last result |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_din | output | 1 | Serial command to the converter |
| adc_dout | input | 1 | Serial result from the converter |

## Verification
The bench drives half-period requests of 0, 1 and 1100. A divider without the clamp would run the serial clock outside its legal band, and the per-cycle comparison would catch the clock edges at the wrong times. Requests are injected mid-frame, inside the quiet interval, and a second time while one is already held. A design that lost the held request, launched it early and cut the quiet gap short, or queued the extra one would show as a chip-select or busy mismatch or a command word sent out of turn. A negative sample and both input ranges check the sign field and the range-dependent setup delay.

// File: rtl/afm_pkg.sv
package afm_pkg;

   localparam int unsigned FRAME_BITS = 16;
   localparam int unsigned RX_BITS    = FRAME_BITS - 1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_LOW,
      ST_HIGH,
      ST_GAP
   } afm_state_e;

   typedef struct packed {
      logic [1:0]  chan;
      logic        sign;
      logic [12:0] value;
   } afm_result_t;

   function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                input int unsigned clk_khz);
      return (ns * clk_khz + 999_999) / 1_000_000;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/afm_div_sel.sv
module afm_div_sel #(
   parameter int unsigned DIV_W      = 12,
   parameter int unsigned HALF_MIN   = 5,
   parameter int unsigned HALF_MAX   = 1000,
   parameter int unsigned OOR_REJECT = 0
)(
   input  logic [DIV_W-1:0] half_req,
   output logic [DIV_W-1:0] half_eff
);
   localparam logic [DIV_W-1:0] LIM_LO = DIV_W'(HALF_MIN);
   localparam logic [DIV_W-1:0] LIM_HI = DIV_W'(HALF_MAX);

   logic too_low;
   logic too_high;

   assign too_low  = half_req < LIM_LO;
   assign too_high = half_req > LIM_HI;

   generate
      if (OOR_REJECT == 0) begin : g_clamp
         always_comb begin
            if (too_low)       half_eff = LIM_LO;
            else if (too_high) half_eff = LIM_HI;
            else               half_eff = half_req;
         end
      end else begin : g_reject
         always_comb begin
            if (too_low || too_high) half_eff = LIM_HI;
            else                     half_eff = half_req;
         end
      end
   endgenerate

endmodule

// File: rtl/afm_shift.sv
module afm_shift #(
   parameter int unsigned TX_BITS = 16,
   parameter int unsigned RX_BITS = 15
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [TX_BITS-1:0] load_word,
   input  logic               tx_adv,
   input  logic               rx_take,
   input  logic               ser_in,
   output logic               ser_out,
   output logic [RX_BITS-1:0] rx_word
);
   logic [TX_BITS-1:0] tx_q;
   logic [RX_BITS-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
      end else if (load) begin
         tx_q <= load_word;
      end else if (tx_adv) begin
         tx_q <= {tx_q[TX_BITS-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
      end else if (rx_take) begin
         rx_q <= {rx_q[RX_BITS-2:0], ser_in};
      end
   end

   assign ser_out = tx_q[TX_BITS-1];
   assign rx_word = rx_q;

endmodule

// File: rtl/afm_result.sv
module afm_result
   import afm_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture,
   input  logic [RX_BITS-1:0] word,
   output logic               valid,
   output afm_result_t        res
);
   afm_result_t parsed;

   always_comb begin
      parsed.chan  = word[RX_BITS-1 -: 2];
      parsed.sign  = word[RX_BITS-3];
      parsed.value = word[RX_BITS-3:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         res   <= '0;
      end else begin
         valid <= capture;
         if (capture) res <= parsed;
      end
   end

endmodule

// File: rtl/afm_frame_master.sv
module afm_frame_master
   import afm_pkg::*;
#(
   parameter int unsigned SYS_CLK_HZ   = 100_000_000,
   parameter int unsigned SCLK_MIN_HZ  = 50_000,
   parameter int unsigned SCLK_MAX_HZ  = 10_000_000,
   parameter int unsigned SETUP_BIP_NS = 25,
   parameter int unsigned SETUP_UNI_NS = 45,
   parameter int unsigned QUIET_NS     = 75,
   parameter int unsigned CS_HIGH_NS   = 12,
   parameter int unsigned DIV_W        = 12,
   parameter int unsigned OOR_REJECT   = 0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [15:0]      cmd_word,
   input  logic             range_unipolar,
   input  logic [DIV_W-1:0] half_div,
   output logic             busy,
   output logic             res_valid,
   output logic [1:0]       res_chan,
   output logic             res_sign,
   output logic [12:0]      res_value,
   output logic             adc_cs_n,
   output logic             adc_sclk,
   output logic             adc_din,
   input  logic             adc_dout
);
   localparam int unsigned CLK_KHZ        = SYS_CLK_HZ / 1000;
   localparam int unsigned HALF_MIN       = (SYS_CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
   localparam int unsigned HALF_MAX       = SYS_CLK_HZ / (2 * SCLK_MIN_HZ);
   localparam int unsigned SETUP_BIP_CYC  = ns_to_cycles(SETUP_BIP_NS, CLK_KHZ);
   localparam int unsigned SETUP_UNI_CYC  = ns_to_cycles(SETUP_UNI_NS, CLK_KHZ);
   localparam int unsigned GAP_CYC        = umax(ns_to_cycles(QUIET_NS, CLK_KHZ),
                                                 ns_to_cycles(CS_HIGH_NS, CLK_KHZ));
   localparam int unsigned CNT_MAX        = umax(umax(HALF_MAX, GAP_CYC),
                                                 umax(SETUP_BIP_CYC, SETUP_UNI_CYC));
   localparam int unsigned CNT_W          = $clog2(CNT_MAX + 1);
   localparam int unsigned NB_W           = $clog2(FRAME_BITS + 1);

   // elaboration-time parameter checks
   if (HALF_MIN < 1 || HALF_MIN > HALF_MAX) begin : g_bad_band
      $error("afm_frame_master: serial clock band empty for this system clock");
   end
   if (HALF_MAX >= (2 ** DIV_W)) begin : g_bad_divw
      $error("afm_frame_master: DIV_W too narrow for the slowest half-period");
   end
   if (SETUP_BIP_CYC < 1 || SETUP_UNI_CYC < 1 || GAP_CYC < 1) begin : g_bad_delay
      $error("afm_frame_master: setup and quiet delays must be at least one cycle");
   end

   afm_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [NB_W-1:0]   nfall;
   logic [DIV_W-1:0]  half_q;

   logic              pend;
   logic [15:0]       pend_cmd;
   logic              pend_uni;
   logic [DIV_W-1:0]  pend_half;

   logic              launch;
   logic [15:0]       l_cmd;
   logic              l_uni;
   logic [DIV_W-1:0]  l_half;
   logic [DIV_W-1:0]  half_eff;
   logic [CNT_W-1:0]  setup_m1;
   logic [CNT_W-1:0]  half_m1;

   logic              cnt_done;
   logic              last_fall;
   logic              fall_now;
   logic              rise_now;
   logic              end_now;
   logic              rx_take;

   logic [RX_BITS-1:0] rx_word;
   afm_result_t        res;

   // ---------------------------------------------------------------- launch select
   assign launch = (state == ST_IDLE) && (pend || start);
   assign l_cmd  = pend ? pend_cmd  : cmd_word;
   assign l_uni  = pend ? pend_uni  : range_unipolar;
   assign l_half = pend ? pend_half : half_div;

   afm_div_sel #(
      .DIV_W      (DIV_W),
      .HALF_MIN   (HALF_MIN),
      .HALF_MAX   (HALF_MAX),
      .OOR_REJECT (OOR_REJECT)
   ) u_div (
      .half_req (l_half),
      .half_eff (half_eff)
   );

   assign setup_m1 = l_uni ? CNT_W'(SETUP_UNI_CYC - 1) : CNT_W'(SETUP_BIP_CYC - 1);
   assign half_m1  = CNT_W'(half_q - 1'b1);

   // ---------------------------------------------------------------- pending slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_cmd  <= '0;
         pend_uni  <= 1'b0;
         pend_half <= '0;
      end else if (state == ST_IDLE) begin
         pend <= 1'b0;
      end else if (start && !pend) begin
         pend      <= 1'b1;
         pend_cmd  <= cmd_word;
         pend_uni  <= range_unipolar;
         pend_half <= half_div;
      end
   end

   // ---------------------------------------------------------------- frame sequencer
   assign cnt_done  = (cnt == '0);
   assign last_fall = (nfall == NB_W'(FRAME_BITS));
   assign fall_now  = cnt_done && ((state == ST_SETUP) || (state == ST_HIGH && !last_fall));
   assign rise_now  = cnt_done && (state == ST_LOW);
   assign end_now   = cnt_done && (state == ST_HIGH) && last_fall;
   assign rx_take   = fall_now && (nfall < NB_W'(RX_BITS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         nfall    <= '0;
         half_q   <= DIV_W'(HALF_MIN);
         adc_cs_n <= 1'b1;
         adc_sclk <= 1'b1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (launch) begin
                  state    <= ST_SETUP;
                  cnt      <= setup_m1;
                  nfall    <= '0;
                  half_q   <= half_eff;
                  adc_cs_n <= 1'b0;
               end
            end
            ST_SETUP, ST_HIGH: begin
               if (end_now) begin
                  state    <= ST_GAP;
                  cnt      <= CNT_W'(GAP_CYC - 1);
                  adc_cs_n <= 1'b1;
               end else if (fall_now) begin
                  state    <= ST_LOW;
                  cnt      <= half_m1;
                  nfall    <= nfall + 1'b1;
                  adc_sclk <= 1'b0;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_LOW: begin
               if (rise_now) begin
                  state    <= ST_HIGH;
                  cnt      <= half_m1;
                  adc_sclk <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_GAP: begin
               if (cnt_done) state <= ST_IDLE;
               else          cnt   <= cnt - 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // ---------------------------------------------------------------- data path
   afm_shift #(
      .TX_BITS (FRAME_BITS),
      .RX_BITS (RX_BITS)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (launch),
      .load_word (l_cmd),
      .tx_adv    (rise_now),
      .rx_take   (rx_take),
      .ser_in    (adc_dout),
      .ser_out   (adc_din),
      .rx_word   (rx_word)
   );

   afm_result u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (end_now),
      .word    (rx_word),
      .valid   (res_valid),
      .res     (res)
   );

   assign busy      = (state != ST_IDLE);
   assign res_chan  = res.chan;
   assign res_sign  = res.sign;
   assign res_value = res.value;

endmodule

// File: rtl/afm_checker.sv
module afm_checker #(
   parameter int unsigned HALF_MIN  = 5,
   parameter int unsigned HALF_MAX  = 1000,
   parameter int unsigned SETUP_MIN = 3,
   parameter int unsigned GAP_CYC   = 8
)(
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sclk,
   input logic din,
   input logic busy,
   input logic res_valid
);
   logic          sclk_q;
   logic [5:0]    fcnt;
   int unsigned   lo_cnt;
   int unsigned   hi_cnt;
   int unsigned   su_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b1;
         fcnt   <= '0;
         lo_cnt <= 0;
         hi_cnt <= GAP_CYC + 1;
         su_cnt <= 0;
      end else begin
         sclk_q <= sclk;
         if (cs_n)                 fcnt <= '0;
         else if (sclk_q && !sclk) fcnt <= fcnt + 1'b1;
         if (sclk) lo_cnt <= 0;
         else      lo_cnt <= lo_cnt + 1;
         if (!cs_n)                  hi_cnt <= 0;
         else if (hi_cnt <= GAP_CYC) hi_cnt <= hi_cnt + 1;
         if (cs_n)                          su_cnt <= 0;
         else if (sclk && fcnt == '0)       su_cnt <= su_cnt + 1;
      end
   end

   // R2: serial clock parked high outside a frame
   a_r2_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   // R2: sixteen falling edges per frame
   a_r2_sixteen_falls: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (fcnt == 6'd16));

   // R3, R4: low phase inside the legal band
   a_r3_low_phase_band: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> (lo_cnt >= HALF_MIN && lo_cnt <= HALF_MAX));

   // R5: setup delay before the first falling edge
   a_r5_setup_min: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sclk) && fcnt == '0) |-> (su_cnt >= SETUP_MIN));

   // R6: data-in moves only with a rising edge or a frame launch
   a_r6_din_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(din) |-> ($rose(sclk) || $fell(cs_n)));

   // R8: strobe is a single cycle
   a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R8: strobe coincides with chip select returning high
   a_r8_valid_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $rose(cs_n));

   // R9: quiet interval before the next frame
   a_r9_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (hi_cnt > GAP_CYC));

   // R10: busy covers the whole frame
   a_r10_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

endmodule

bind afm_frame_master afm_checker #(
   .HALF_MIN  (HALF_MIN),
   .HALF_MAX  (HALF_MAX),
   .SETUP_MIN (SETUP_BIP_CYC),
   .GAP_CYC   (GAP_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (adc_cs_n),
   .sclk      (adc_sclk),
   .din       (adc_din),
   .busy      (busy),
   .res_valid (res_valid)
);

// File: tb/sim_afm_frame_master.sv
module sim_afm_frame_master;
   localparam int DW   = 12;
   localparam int SB   = 3;
   localparam int SU   = 5;
   localparam int GAP  = 8;
   localparam int HMIN = 5;
   localparam int HMAX = 1000;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [15:0]   cmd = '0;
   logic          uni = 1'b0;
   logic [DW-1:0] half_div = DW'(5);
   logic          dout = 1'b0;
   logic          busy, res_valid, res_sign, cs_n, sclk, din;
   logic [1:0]    res_chan;
   logic [12:0]   res_value;

   afm_frame_master u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .start          (start),
      .cmd_word       (cmd),
      .range_unipolar (uni),
      .half_div       (half_div),
      .busy           (busy),
      .res_valid      (res_valid),
      .res_chan       (res_chan),
      .res_sign       (res_sign),
      .res_value      (res_value),
      .adc_cs_n       (cs_n),
      .adc_sclk       (sclk),
      .adc_din        (din),
      .adc_dout       (dout)
   );

   int    n_chk  = 0;
   int    n_fail = 0;
   string cs_tag = "R2";
   string ck_tag = "R3";

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // ------------------------------------------------------------ converter model
   logic [15:0] resp_tab [16];
   logic [15:0] cmd_exp  [16];
   int          conv_idx = 0;
   logic [15:0] conv_word = '0;
   logic [15:0] din_got = '0;
   int          din_bits = 0;

   always @(negedge cs_n) if (rst_n) begin
      conv_word = resp_tab[conv_idx];
      dout      = conv_word[15];
      conv_idx++;
      din_got   = '0;
      din_bits  = 0;
   end

   always @(negedge sclk) if (rst_n && !cs_n) begin
      din_got   = {din_got[14:0], din};
      din_bits++;
      conv_word = {conv_word[14:0], 1'b0};
      dout      = conv_word[15];
   end

   always @(posedge cs_n) if (rst_n && conv_idx > 0) begin
      check(din_bits == 16, "R2", "falling edges seen by converter", din_bits, 16);
      check(din_got == cmd_exp[conv_idx-1], "R6", "command word received",
            int'(din_got), int'(cmd_exp[conv_idx-1]));
   end

   // ------------------------------------------------------------ reference timeline
   logic        e_cs = 1'b1, e_sclk = 1'b1, e_busy = 1'b0, e_valid = 1'b0;
   logic [15:0] e_word = '0;
   int          mod_idx = 0;
   bit          m_pend = 1'b0;
   logic [15:0] p_cmd = '0;
   bit          p_uni = 1'b0;
   int          p_half = 0;

   task automatic tick();
      @(posedge clk);
      if (start && !m_pend) begin
         m_pend = 1'b1;
         p_cmd  = cmd;
         p_uni  = uni;
         p_half = int'(half_div);
      end
   endtask

   task automatic run_frame(input logic [15:0] c, input bit u, input int hreq);
      int h;
      int s;
      h = (hreq < HMIN) ? HMIN : ((hreq > HMAX) ? HMAX : hreq);
      s = u ? SU : SB;
      cmd_exp[mod_idx] = c;
      e_word = resp_tab[mod_idx];
      mod_idx++;
      e_cs   = 1'b0;
      e_busy = 1'b1;
      repeat (s) tick();
      for (int k = 0; k < 16; k++) begin
         e_sclk = 1'b0;
         repeat (h) tick();
         e_sclk = 1'b1;
         repeat (h) tick();
      end
      e_cs    = 1'b1;
      e_valid = 1'b1;
      tick();
      e_valid = 1'b0;
      repeat (GAP - 1) tick();
      e_busy = 1'b0;
   endtask

   initial begin : ref_model
      wait (rst_n);
      forever begin
         @(posedge clk);
         if (m_pend) begin
            m_pend = 1'b0;
            run_frame(p_cmd, p_uni, p_half);
         end else if (start) begin
            run_frame(cmd, uni, int'(half_div));
         end
      end
   end

   // ------------------------------------------------------------ per-cycle compare
   always @(negedge clk) if (rst_n) begin
      check(cs_n == e_cs,           cs_tag, "chip select", cs_n, e_cs);
      check(sclk == e_sclk,         ck_tag, "serial clock", sclk, e_sclk);
      check(busy == e_busy,         "R10",  "busy", busy, e_busy);
      check(res_valid == e_valid,   "R8",   "result strobe", res_valid, e_valid);
      if (e_valid) begin
         check(res_chan == e_word[15:14], "R7", "channel", res_chan, e_word[15:14]);
         check(res_sign == e_word[13],    "R7", "sign", res_sign, e_word[13]);
         check(res_value == e_word[13:1], "R7", "value", res_value, e_word[13:1]);
      end
   end

   // ------------------------------------------------------------ stimulus
   task automatic pulse_start(input logic [15:0] c, input bit u, input int h);
      @(negedge clk);
      cmd      = c;
      uni      = u;
      half_div = DW'(h);
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (e_busy || busy || m_pend);
      repeat (3) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200_000) @(posedge clk);
      check(1'b0, "R10", "watchdog expired, busy stuck", int'(busy), 0);
      finish_run();
   end

   initial begin : stim
      resp_tab[0]  = 16'b01_0_101010101010_0;
      resp_tab[1]  = 16'b11_1_000000000011_0;
      resp_tab[2]  = 16'b10_0_111111111111_0;
      resp_tab[3]  = 16'b00_1_111111111111_0;
      resp_tab[4]  = 16'b01_1_000000000000_0;
      resp_tab[5]  = 16'b10_0_000000000001_0;
      resp_tab[6]  = 16'b11_0_011001100110_0;
      resp_tab[7]  = 16'b00_1_100110011001_0;
      resp_tab[8]  = 16'b01_0_000011110000_0;
      for (int i = 9; i < 16; i++) resp_tab[i] = 16'h0000;

      repeat (4) @(negedge clk);
      // R1: reset values
      check(cs_n == 1'b1,      "R1", "reset chip select", cs_n, 1);
      check(sclk == 1'b1,      "R1", "reset serial clock", sclk, 1);
      check(din == 1'b0,       "R1", "reset data-in", din, 0);
      check(busy == 1'b0,      "R1", "reset busy", busy, 0);
      check(res_valid == 1'b0, "R1", "reset strobe", res_valid, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2 R3 R6 R7: bipolar, fastest legal clock, positive sample
      pulse_start(16'hA5C3, 1'b0, 5);
      wait_idle();

      // R5: unipolar setup delay, negative sample
      cs_tag = "R5";
      pulse_start(16'h8E17, 1'b1, 7);
      wait_idle();
      cs_tag = "R2";

      // R4: requests below the band
      ck_tag = "R4";
      pulse_start(16'h3C5A, 1'b0, 1);
      wait_idle();
      pulse_start(16'hFFFF, 1'b0, 0);
      wait_idle();
      // R4: request above the band, unipolar
      pulse_start(16'h0001, 1'b1, 1100);
      wait_idle();
      ck_tag = "R3";

      // R10: mid-frame request held, third request dropped
      cs_tag = "R9";
      pulse_start(16'h1234, 1'b0, 6);
      repeat (40) @(negedge clk);
      pulse_start(16'hBEEF, 1'b1, 5);
      repeat (20) @(negedge clk);
      pulse_start(16'h7777, 1'b0, 9);
      wait_idle();

      // R9 R10: request placed inside the quiet interval
      pulse_start(16'h5A5A, 1'b0, 5);
      @(posedge cs_n);
      repeat (3) @(negedge clk);
      pulse_start(16'hC001, 1'b1, 8);
      wait_idle();

      check(conv_idx == 9, "R10", "frames run", conv_idx, 9);
      check(res_value == 13'b0_000011110000, "R8", "fields held after strobe",
            int'(res_value), 240);
      finish_run();
   end

endmodule